// File: doc/BRIEF.md
# Halt, Wake-up and Reset Sequencer

This block sequences the power states and the reset outputs of a small microcontroller core. After power-up it holds the core in cold reset while a start-up stabilisation timer runs. It then lets the core run. The core can ask to halt. The core can also issue a clear-watchdog command, and a watchdog time-out pulse arrives from an external counter. An external reset pin, per-bit port wake inputs and interrupt request lines can each end a halt. The block reports the cause of the most recent reset or wake through two status flags: a time-out flag and a power-down flag.

A wake from halt always waits out the full start-up interval. After that interval the block does one of two things. For a wake caused by the watchdog, it gives a one-cycle warm reset, which restarts only the program counter and stack pointer. For any other wake, it gives a one-cycle resume strobe with an action code that tells the core to continue at the next instruction or to take the interrupt. A reset from the external pin skips the start-up interval. Port and interrupt inputs pass through a two-flop synchroniser on the system clock. The external reset pin is synchronised the same way. The core-side pulses (halt, clear-watchdog, watchdog time-out) are taken as synchronous.

Top module: `halt_wake_seq`

## Requirements
- R1: While `por_n` is low, `cold_rst` is 1, `core_run` is 0 and both flags are 0. After `por_n` rises, `cold_rst` stays 1 for exactly STARTUP_CYC (default 1024) clock edges, and then `core_run` becomes 1.
- R2: A `halt_req` pulse while running stops the core from the next cycle. From that cycle the power-down flag is 1, the time-out flag is 0, and `wdt_clr` pulses high for exactly one cycle.
- R3: A `clrwdt_req` pulse while running clears the power-down flag from the next cycle, leaves the time-out flag unchanged, and pulses `wdt_clr` for one cycle.
- R4: A `wdt_tmo` pulse while running gives one cycle of `cold_rst` and sets the time-out flag. The power-down flag is unchanged. The core runs again in the following cycle, with no start-up delay.
- R5: A `wdt_tmo` pulse while halted sets both flags at once. After the STARTUP_CYC delay it gives a single `warm_rst` cycle with no `resume_stb`, and then the core runs.
- R6: While halted, a falling edge on a port bit whose `port_wake_en` bit is 1 wakes the block. The edge is seen after two synchroniser flops. A falling edge on a disabled bit does nothing, and neither does a rising edge. A port wake produces action code 2'b01 (next instruction).
- R7: An interrupt wake produces action code 2'b10 (take interrupt) when the waking request has its `irq_en` bit set and `stack_full` is 0. In every other case it produces 2'b01.
- R8: An interrupt request that is already high when the halt is entered cannot wake the block during that halt.
- R9: A low level on the synchronised `ext_rst_n` puts the block in cold reset from the next cycle. The core runs in the cycle after the synchronised pin goes high again. Both flags are unchanged if the reset came while running. If the reset came while halted or during the wake delay, the time-out flag becomes 0 and the power-down flag becomes 1.
- R10: When events meet in the same cycle, the pin reset wins over a watchdog time-out, the time-out wins over an interrupt, and an interrupt wins over a port wake.
- R11: `resume_stb` and `warm_rst` last exactly one cycle and never coincide with `core_run` or `cold_rst`. `core_run` rises in the next cycle. `resume_act` is 2'b00 whenever `resume_stb` is 0.
- R12: During a start-up delay, `wdt_tmo`, `halt_req` and `clrwdt_req` have no effect. While halted, `halt_req` and `clrwdt_req` also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, always running |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset pin, active low, synchronised inside |
| halt_req | input | 1 | One-cycle halt request from the core |
| clrwdt_req | input | 1 | One-cycle clear-watchdog command from the core |
| wdt_tmo | input | 1 | One-cycle watchdog time-out pulse |
| port_in | input | PORT_W | Port pins used as wake sources |
| port_wake_en | input | PORT_W | Per-bit wake enable for `port_in` |
| irq_req | input | IRQ_W | Interrupt request flags |
| irq_en | input | IRQ_W | Per-request interrupt enable |
| stack_full | input | 1 | Core return stack is full |
| core_run | output | 1 | Core clock enable |
| cold_rst | output | 1 | Full reset of the core |
| warm_rst | output | 1 | One-cycle reset of the program counter and stack pointer only |
| wdt_clr | output | 1 | One-cycle clear of the watchdog counter |
| flag_timeout | output | 1 | Time-out status flag |
| flag_powerdown | output | 1 | Power-down status flag |
| resume_stb | output | 1 | One-cycle resume strobe after a non-watchdog wake |
| resume_act | output | 2 | Wake action: 2'b01 next instruction, 2'b10 take interrupt, 2'b00 idle |

## Verification
The hardest case to reach from the ports is two wake sources that are evaluated in the same cycle. Port and interrupt inputs pass through two synchroniser flops and an edge register. The watchdog pulse and the core pulses are used as they arrive. To line up a port fall with a time-out in the same evaluation cycle, the stimulus drives the watchdog pulse two cycles after the port edge. It uses the same offset to line up a pin reset with a time-out during halt. An interrupt that is already pending at halt entry is reached by raising the request a few cycles before the halt, holding it through the halt, and then waking with a port edge. The time of the resume strobe and its action code then show that the interrupt was masked.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

   typedef enum logic [2:0] {
      ST_BOOT   = 3'd0,
      ST_RUN    = 3'd1,
      ST_HALT   = 3'd2,
      ST_WAKE   = 3'd3,
      ST_RESUME = 3'd4,
      ST_WDRST  = 3'd5,
      ST_PINRST = 3'd6
   } hwr_state_e;

   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_NEXT = 2'b01,
      ACT_TAKE = 2'b10
   } wake_act_e;

   typedef enum logic {
      WK_RESUME = 1'b0,
      WK_WARM   = 1'b1
   } wake_kind_e;

endpackage

// File: rtl/hwr_sync.sv
module hwr_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hwr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hwr_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= {STAGES{RST_VAL}};
      end else begin
         stage_q <= {stage_q[STAGES-2:0], d};
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/hwr_startup_timer.sv
module hwr_startup_timer #(
   parameter int CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);

   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("hwr_startup_timer: CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LOAD_VAL;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/hwr_wake_detect.sv
module hwr_wake_detect #(
   parameter int PORT_W = 8,
   parameter int IRQ_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] port_s,
   input  logic [PORT_W-1:0] port_en,
   input  logic [IRQ_W-1:0]  irq_s,
   input  logic [IRQ_W-1:0]  irq_en,
   input  logic              stack_full,
   input  logic              capture,
   output logic              port_wake,
   output logic              irq_wake,
   output logic              irq_take
);

   logic [PORT_W-1:0] port_prev_q;
   logic [PORT_W-1:0] port_fall;
   logic [IRQ_W-1:0]  blk_q;
   logic [IRQ_W-1:0]  irq_live;
   logic [IRQ_W-1:0]  irq_serve;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_prev_q <= '1;
         blk_q       <= '0;
      end else begin
         port_prev_q <= port_s;
         if (capture) begin
            blk_q <= irq_s;
         end
      end
   end

   generate
      for (genvar p = 0; p < PORT_W; p++) begin : g_port
         assign port_fall[p] = port_en[p] & port_prev_q[p] & ~port_s[p];
      end
      for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
         assign irq_live[i]  = irq_s[i] & ~blk_q[i];
         assign irq_serve[i] = irq_live[i] & irq_en[i];
      end
   endgenerate

   assign port_wake = |port_fall;
   assign irq_wake  = |irq_live;
   assign irq_take  = (|irq_serve) & ~stack_full;

endmodule

// File: rtl/hwr_seq_fsm.sv
module hwr_seq_fsm
   import hwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_rst,
   input  logic       wdt_tmo,
   input  logic       halt_req,
   input  logic       clrwdt_req,
   input  logic       irq_wake,
   input  logic       irq_take,
   input  logic       port_wake,
   input  logic       timer_done,
   output logic       timer_load,
   output logic       timer_run,
   output logic       capture,
   output logic       core_run,
   output logic       cold_rst,
   output logic       warm_rst,
   output logic       wdt_clr,
   output logic       flag_timeout,
   output logic       flag_powerdown,
   output logic       resume_stb,
   output logic [1:0] resume_act
);

   hwr_state_e state_q, state_d;
   wake_kind_e kind_q, kind_d;
   wake_act_e  act_q, act_d;
   logic       to_q, to_d;
   logic       pd_q, pd_d;
   logic       clr_q, clr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_BOOT;
         kind_q  <= WK_RESUME;
         act_q   <= ACT_NONE;
         to_q    <= 1'b0;
         pd_q    <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         kind_q  <= kind_d;
         act_q   <= act_d;
         to_q    <= to_d;
         pd_q    <= pd_d;
         clr_q   <= clr_d;
      end
   end

   always_comb begin
      state_d    = state_q;
      kind_d     = kind_q;
      act_d      = act_q;
      to_d       = to_q;
      pd_d       = pd_q;
      clr_d      = 1'b0;
      timer_load = 1'b0;
      capture    = 1'b0;
      unique case (state_q)
         ST_BOOT: begin
            if (pin_rst) begin
               state_d = ST_PINRST;
            end else if (timer_done) begin
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (pin_rst) begin
               state_d = ST_PINRST;
            end else if (wdt_tmo) begin
               state_d = ST_WDRST;
               to_d    = 1'b1;
            end else if (halt_req) begin
               state_d = ST_HALT;
               pd_d    = 1'b1;
               to_d    = 1'b0;
               capture = 1'b1;
               clr_d   = 1'b1;
            end else if (clrwdt_req) begin
               pd_d  = 1'b0;
               clr_d = 1'b1;
            end
         end
         ST_HALT: begin
            if (pin_rst) begin
               state_d = ST_PINRST;
               to_d    = 1'b0;
               pd_d    = 1'b1;
            end else if (wdt_tmo) begin
               state_d    = ST_WAKE;
               kind_d     = WK_WARM;
               act_d      = ACT_NONE;
               to_d       = 1'b1;
               pd_d       = 1'b1;
               timer_load = 1'b1;
            end else if (irq_wake) begin
               state_d    = ST_WAKE;
               kind_d     = WK_RESUME;
               act_d      = irq_take ? ACT_TAKE : ACT_NEXT;
               timer_load = 1'b1;
            end else if (port_wake) begin
               state_d    = ST_WAKE;
               kind_d     = WK_RESUME;
               act_d      = ACT_NEXT;
               timer_load = 1'b1;
            end
         end
         ST_WAKE: begin
            if (pin_rst) begin
               state_d = ST_PINRST;
               to_d    = 1'b0;
               pd_d    = 1'b1;
            end else if (timer_done) begin
               state_d = ST_RESUME;
            end
         end
         ST_RESUME, ST_WDRST, ST_PINRST: begin
            state_d = pin_rst ? ST_PINRST : ST_RUN;
         end
         default: begin
            state_d = ST_BOOT;
         end
      endcase
   end

   assign timer_run      = (state_q == ST_BOOT) || (state_q == ST_WAKE);
   assign core_run       = (state_q == ST_RUN);
   assign cold_rst       = (state_q == ST_BOOT) || (state_q == ST_WDRST) ||
                           (state_q == ST_PINRST);
   assign warm_rst       = (state_q == ST_RESUME) && (kind_q == WK_WARM);
   assign resume_stb     = (state_q == ST_RESUME) && (kind_q == WK_RESUME);
   assign resume_act     = resume_stb ? act_q : ACT_NONE;
   assign wdt_clr        = clr_q;
   assign flag_timeout   = to_q;
   assign flag_powerdown = pd_q;

endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
   parameter int PORT_W      = 8,
   parameter int IRQ_W       = 4,
   parameter int STARTUP_CYC = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst_n,
   input  logic              halt_req,
   input  logic              clrwdt_req,
   input  logic              wdt_tmo,
   input  logic [PORT_W-1:0] port_in,
   input  logic [PORT_W-1:0] port_wake_en,
   input  logic [IRQ_W-1:0]  irq_req,
   input  logic [IRQ_W-1:0]  irq_en,
   input  logic              stack_full,
   output logic              core_run,
   output logic              cold_rst,
   output logic              warm_rst,
   output logic              wdt_clr,
   output logic              flag_timeout,
   output logic              flag_powerdown,
   output logic              resume_stb,
   output logic [1:0]        resume_act
);

   generate
      if (PORT_W < 1) begin : g_bad_port
         $error("halt_wake_seq: PORT_W must be at least 1");
      end
      if (IRQ_W < 1) begin : g_bad_irq
         $error("halt_wake_seq: IRQ_W must be at least 1");
      end
   endgenerate

   logic              ext_s;
   logic              pin_rst;
   logic [PORT_W-1:0] port_s;
   logic [IRQ_W-1:0]  irq_s;
   logic              port_wake, irq_wake, irq_take;
   logic              capture;
   logic              timer_load, timer_run, timer_done;

   hwr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
      .clk(clk), .rst_n(por_n), .d(ext_rst_n), .q(ext_s)
   );

   hwr_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL({PORT_W{1'b1}})) u_sync_port (
      .clk(clk), .rst_n(por_n), .d(port_in), .q(port_s)
   );

   hwr_sync #(.W(IRQ_W), .STAGES(SYNC_STAGES), .RST_VAL({IRQ_W{1'b0}})) u_sync_irq (
      .clk(clk), .rst_n(por_n), .d(irq_req), .q(irq_s)
   );

   assign pin_rst = ~ext_s;

   hwr_wake_detect #(.PORT_W(PORT_W), .IRQ_W(IRQ_W)) u_detect (
      .clk        (clk),
      .rst_n      (por_n),
      .port_s     (port_s),
      .port_en    (port_wake_en),
      .irq_s      (irq_s),
      .irq_en     (irq_en),
      .stack_full (stack_full),
      .capture    (capture),
      .port_wake  (port_wake),
      .irq_wake   (irq_wake),
      .irq_take   (irq_take)
   );

   hwr_startup_timer #(.CYCLES(STARTUP_CYC)) u_timer (
      .clk   (clk),
      .rst_n (por_n),
      .load  (timer_load),
      .run   (timer_run),
      .done  (timer_done)
   );

   hwr_seq_fsm u_fsm (
      .clk            (clk),
      .rst_n          (por_n),
      .pin_rst        (pin_rst),
      .wdt_tmo        (wdt_tmo),
      .halt_req       (halt_req),
      .clrwdt_req     (clrwdt_req),
      .irq_wake       (irq_wake),
      .irq_take       (irq_take),
      .port_wake      (port_wake),
      .timer_done     (timer_done),
      .timer_load     (timer_load),
      .timer_run      (timer_run),
      .capture        (capture),
      .core_run       (core_run),
      .cold_rst       (cold_rst),
      .warm_rst       (warm_rst),
      .wdt_clr        (wdt_clr),
      .flag_timeout   (flag_timeout),
      .flag_powerdown (flag_powerdown),
      .resume_stb     (resume_stb),
      .resume_act     (resume_act)
   );

endmodule

// File: rtl/hwr_checker.sv
module hwr_checker (
   input logic       clk,
   input logic       por_n,
   input logic       pin_rst,
   input logic       halt_req,
   input logic       clrwdt_req,
   input logic       wdt_tmo,
   input logic       core_run,
   input logic       cold_rst,
   input logic       warm_rst,
   input logic       wdt_clr,
   input logic       flag_timeout,
   input logic       flag_powerdown,
   input logic       resume_stb,
   input logic [1:0] resume_act
);

   AST_COLD_HOLDS_CORE: assert property (@(posedge clk) disable iff (!por_n)
      cold_rst |-> !core_run); // R1

   AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      (core_run && halt_req && !wdt_tmo && !pin_rst)
      |=> (!core_run && flag_powerdown && !flag_timeout && wdt_clr)); // R2

   AST_CLRWDT_PD: assert property (@(posedge clk) disable iff (!por_n)
      (core_run && clrwdt_req && !halt_req && !wdt_tmo && !pin_rst)
      |=> (!flag_powerdown && wdt_clr && $stable(flag_timeout))); // R3

   AST_WDT_RUN_COLD: assert property (@(posedge clk) disable iff (!por_n)
      (core_run && wdt_tmo && !pin_rst)
      |=> (cold_rst && flag_timeout && $stable(flag_powerdown))); // R4

   AST_WARM_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
      warm_rst |-> (flag_timeout && flag_powerdown)); // R5

   AST_PIN_COLD: assert property (@(posedge clk) disable iff (!por_n)
      pin_rst |=> cold_rst); // R9

   AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0({resume_stb, warm_rst, core_run, cold_rst})); // R11

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      ((resume_stb || warm_rst) && !pin_rst) |=> (core_run && !resume_stb && !warm_rst)); // R11

   AST_ACT_QUIET: assert property (@(posedge clk) disable iff (!por_n)
      !resume_stb |-> (resume_act == 2'b00)); // R11

   AST_ACT_VALID: assert property (@(posedge clk) disable iff (!por_n)
      resume_stb |-> ($countones(resume_act) == 1)); // R7

endmodule

bind halt_wake_seq hwr_checker u_chk (
   .clk            (clk),
   .por_n          (por_n),
   .pin_rst        (pin_rst),
   .halt_req       (halt_req),
   .clrwdt_req     (clrwdt_req),
   .wdt_tmo        (wdt_tmo),
   .core_run       (core_run),
   .cold_rst       (cold_rst),
   .warm_rst       (warm_rst),
   .wdt_clr        (wdt_clr),
   .flag_timeout   (flag_timeout),
   .flag_powerdown (flag_powerdown),
   .resume_stb     (resume_stb),
   .resume_act     (resume_act)
);

// File: tb/test_halt_wake_seq.sv
`timescale 1ns/1ps
module test_halt_wake_seq;

   localparam int N  = 1024;
   localparam int PW = 8;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          por_n, ext_rst_n, halt_req, clrwdt_req, wdt_tmo, stack_full;
   logic [PW-1:0] port_in, port_wake_en;
   logic [IW-1:0] irq_req, irq_en;
   logic          core_run, cold_rst, warm_rst, wdt_clr, flag_timeout, flag_powerdown;
   logic          resume_stb;
   logic [1:0]    resume_act;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   halt_wake_seq #(.PORT_W(PW), .IRQ_W(IW), .STARTUP_CYC(N)) i_halt_wake_seq (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .halt_req(halt_req),
      .clrwdt_req(clrwdt_req), .wdt_tmo(wdt_tmo), .port_in(port_in),
      .port_wake_en(port_wake_en), .irq_req(irq_req), .irq_en(irq_en),
      .stack_full(stack_full), .core_run(core_run), .cold_rst(cold_rst),
      .warm_rst(warm_rst), .wdt_clr(wdt_clr), .flag_timeout(flag_timeout),
      .flag_powerdown(flag_powerdown), .resume_stb(resume_stb), .resume_act(resume_act)
   );

   // Behavioural reference model. Mode: 0 boot, 1 run, 2 halt, 3 wake delay, 4 resume,
   // 5 watchdog reset, 6 pin reset.
   int            m_mode, m_cnt;
   bit            m_warm, m_to, m_pd, m_clr;
   bit [1:0]      m_act;
   bit            e1, e2;
   bit [PW-1:0]   p1, p2, pp;
   bit [IW-1:0]   q1, q2, blk;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_mode = 0; m_cnt = N - 1; m_warm = 0; m_act = 0;
         m_to = 0; m_pd = 0; m_clr = 0;
         e1 = 1; e2 = 1; p1 = '1; p2 = '1; pp = '1; q1 = '0; q2 = '0; blk = '0;
      end else begin
         bit pr, pw, iw, it;
         pr = !e2;
         pw = |(pp & ~p2 & port_wake_en);
         iw = |(q2 & ~blk);
         it = (|(q2 & ~blk & irq_en)) && !stack_full;
         m_clr = 0;
         case (m_mode)
            0: if (pr) m_mode = 6; else if (m_cnt == 0) m_mode = 1; else m_cnt--;
            1: begin
               if (pr) m_mode = 6;
               else if (wdt_tmo) begin m_mode = 5; m_to = 1; end
               else if (halt_req) begin m_mode = 2; m_pd = 1; m_to = 0; blk = q2; m_clr = 1; end
               else if (clrwdt_req) begin m_pd = 0; m_clr = 1; end
            end
            2: begin
               if (pr) begin m_mode = 6; m_to = 0; m_pd = 1; end
               else if (wdt_tmo) begin m_mode = 3; m_warm = 1; m_to = 1; m_pd = 1; m_cnt = N - 1; end
               else if (iw) begin m_mode = 3; m_warm = 0; m_act = it ? 2'b10 : 2'b01; m_cnt = N - 1; end
               else if (pw) begin m_mode = 3; m_warm = 0; m_act = 2'b01; m_cnt = N - 1; end
            end
            3: begin
               if (pr) begin m_mode = 6; m_to = 0; m_pd = 1; end
               else if (m_cnt == 0) m_mode = 4;
               else m_cnt--;
            end
            default: m_mode = pr ? 6 : 1;
         endcase
         pp = p2; p2 = p1; p1 = port_in;
         e2 = e1; e1 = ext_rst_n;
         q2 = q1; q1 = irq_req;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (!done) begin
         bit stb;
         stb = (m_mode == 4) && !m_warm;
         chk("R1 core_run vs model",       8'(core_run),       8'(m_mode == 1));
         chk("R9 cold_rst vs model",       8'(cold_rst),       8'(m_mode == 0 || m_mode == 5 || m_mode == 6));
         chk("R5 warm_rst vs model",       8'(warm_rst),       8'((m_mode == 4) && m_warm));
         chk("R2 wdt_clr vs model",        8'(wdt_clr),        8'(m_clr));
         chk("R4 flag_timeout vs model",   8'(flag_timeout),   8'(m_to));
         chk("R3 flag_powerdown vs model", 8'(flag_powerdown), 8'(m_pd));
         chk("R11 resume_stb vs model",    8'(resume_stb),     8'(stb));
         chk("R7 resume_act vs model",     8'(resume_act),     stb ? 8'(m_act) : 8'h0);
      end
   end

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic do_halt();
      halt_req = 1'b1; tick(1); halt_req = 1'b0;
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      por_n = 0; ext_rst_n = 1; halt_req = 0; clrwdt_req = 0; wdt_tmo = 0;
      stack_full = 0; port_in = '1; port_wake_en = 8'h0F; irq_req = '0; irq_en = '0;
      tick(3);
      chk("R1 cold in reset", 8'(cold_rst), 8'h1);
      chk("R1 no run in reset", 8'(core_run), 8'h0);
      chk("R1 flags zero", 8'({flag_timeout, flag_powerdown}), 8'h0);
      por_n = 1;
      tick(N - 1);
      chk("R1 cold through delay", 8'(cold_rst), 8'h1);
      tick(1);
      chk("R1 run after delay", 8'(core_run), 8'h1);

      do_halt();
      chk("R2 halted", 8'(core_run), 8'h0);
      chk("R2 flags to0 pd1", 8'({flag_timeout, flag_powerdown}), 8'h1);
      chk("R2 wdt_clr pulse", 8'(wdt_clr), 8'h1);
      tick(1);
      chk("R2 wdt_clr single", 8'(wdt_clr), 8'h0);

      halt_req = 1; clrwdt_req = 1; tick(1); halt_req = 0; clrwdt_req = 0; tick(2);
      chk("R12 clrwdt ignored in halt", 8'(flag_powerdown), 8'h1);
      chk("R12 no wdt_clr in halt", 8'(wdt_clr), 8'h0);

      port_in[7] = 0; tick(2); port_in[7] = 1; tick(4);
      chk("R6 disabled bit ignored", 8'({core_run, resume_stb}), 8'h0);
      port_in[0] = 0;
      tick(N + 2);
      chk("R6 no strobe before delay", 8'(resume_stb), 8'h0);
      tick(1);
      chk("R6 resume strobe", 8'(resume_stb), 8'h1);
      chk("R6 action next", 8'(resume_act), 8'h1);
      tick(1);
      chk("R11 run after strobe", 8'(core_run), 8'h1);
      chk("R11 action idle", 8'(resume_act), 8'h0);
      port_in[0] = 1; tick(3);

      clrwdt_req = 1; tick(1); clrwdt_req = 0;
      chk("R3 pd cleared", 8'(flag_powerdown), 8'h0);
      chk("R3 to unchanged", 8'(flag_timeout), 8'h0);
      chk("R3 wdt_clr", 8'(wdt_clr), 8'h1);

      wdt_tmo = 1; tick(1); wdt_tmo = 0;
      chk("R4 cold pulse", 8'(cold_rst), 8'h1);
      chk("R4 to1 pd unchanged", 8'({flag_timeout, flag_powerdown}), 8'h2);
      tick(1);
      chk("R4 run without delay", 8'(core_run), 8'h1);

      irq_en = 4'b0010; do_halt();
      irq_req = 4'b0010; tick(N + 2);
      chk("R7 no strobe early", 8'(resume_stb), 8'h0);
      tick(1);
      chk("R7 take interrupt", 8'(resume_act), 8'h2);
      irq_req = '0; tick(4);

      stack_full = 1; do_halt();
      irq_req = 4'b0010; tick(N + 3);
      chk("R7 stack full next", 8'(resume_act), 8'h1);
      irq_req = '0; stack_full = 0; tick(4);

      irq_en = '0; do_halt();
      irq_req = 4'b0100; tick(N + 3);
      chk("R7 disabled irq strobe", 8'(resume_stb), 8'h1);
      chk("R7 disabled irq next", 8'(resume_act), 8'h1);
      irq_req = '0; tick(4);

      irq_en = 4'b1000; irq_req = 4'b1000; tick(3); do_halt(); tick(20);
      chk("R8 pending irq no wake", 8'(core_run), 8'h0);
      port_in[1] = 0; tick(N + 2);
      chk("R8 no early strobe", 8'(resume_stb), 8'h0);
      tick(1);
      chk("R8 port wake strobe", 8'(resume_stb), 8'h1);
      chk("R8 action is port next", 8'(resume_act), 8'h1);
      port_in[1] = 1; irq_req = '0; tick(4);

      do_halt();
      wdt_tmo = 1; tick(1); wdt_tmo = 0;
      chk("R5 flags both set", 8'({flag_timeout, flag_powerdown}), 8'h3);
      chk("R5 core stopped", 8'(core_run), 8'h0);
      tick(9);
      wdt_tmo = 1; halt_req = 1; tick(1); wdt_tmo = 0; halt_req = 0;
      tick(N - 11);
      chk("R12 delay not restarted", 8'(warm_rst), 8'h0);
      tick(1);
      chk("R5 warm reset", 8'(warm_rst), 8'h1);
      chk("R5 no resume strobe", 8'(resume_stb), 8'h0);
      tick(1);
      chk("R5 run after warm", 8'(core_run), 8'h1);

      ext_rst_n = 0; tick(2);
      chk("R9 sync latency", 8'(core_run), 8'h1);
      tick(1);
      chk("R9 cold from pin", 8'(cold_rst), 8'h1);
      chk("R9 flags unchanged in run", 8'({flag_timeout, flag_powerdown}), 8'h3);
      tick(5); ext_rst_n = 1; tick(2);
      chk("R9 still cold", 8'(cold_rst), 8'h1);
      tick(1);
      chk("R9 run without delay", 8'(core_run), 8'h1);

      do_halt();
      wdt_tmo = 1; tick(1); wdt_tmo = 0; tick(5);
      ext_rst_n = 0; tick(3);
      chk("R9 cold in wake delay", 8'(cold_rst), 8'h1);
      chk("R9 flags to0 pd1", 8'({flag_timeout, flag_powerdown}), 8'h1);
      ext_rst_n = 1; tick(3);
      chk("R9 run after halt reset", 8'(core_run), 8'h1);

      do_halt();
      port_in[0] = 0; tick(2); wdt_tmo = 1; tick(1); wdt_tmo = 0;
      tick(N);
      chk("R10 watchdog over port", 8'({warm_rst, resume_stb}), 8'h2);
      port_in[0] = 1; tick(3);

      do_halt();
      ext_rst_n = 0; tick(2); wdt_tmo = 1; tick(1); wdt_tmo = 0;
      chk("R10 pin over watchdog cold", 8'(cold_rst), 8'h1);
      chk("R10 pin over watchdog flags", 8'({flag_timeout, flag_powerdown}), 8'h1);
      ext_rst_n = 1; tick(4);

      irq_en = 4'b0010; do_halt();
      irq_req = 4'b0010; port_in[0] = 0; tick(N + 3);
      chk("R10 interrupt over port", 8'(resume_act), 8'h2);
      irq_req = '0; port_in[0] = 1; irq_en = '0; tick(4);

      por_n = 0; tick(2); por_n = 1; tick(5);
      wdt_tmo = 1; halt_req = 1; clrwdt_req = 1; tick(1);
      wdt_tmo = 0; halt_req = 0; clrwdt_req = 0;
      tick(N - 7);
      chk("R12 boot ignores pulses", 8'(cold_rst), 8'h1);
      tick(1);
      chk("R12 run after boot", 8'(core_run), 8'h1);
      chk("R1 flags after power-up", 8'({flag_timeout, flag_powerdown}), 8'h0);

      tick(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule